// File: doc/BRIEF.md
# Buffered SPI Transceiver

This block is a one-word-deep SPI shift engine that runs as a master or as a slave, in SPI mode 0 (clock idles low, data sampled on the rising edge and changed on the falling edge, most significant bit first). The word length is set by `cfg_len`: every word is `cfg_len + 1` bits long. There is one transmit holding register and one receive holding register. A sticky status byte reports receive overrun, transmit underrun and a chip select that was released in the middle of a word.

Transmit words come in on a valid/ready stream. A word is taken on any cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low only while the holding register is occupied. If the shifter is idle when a word is taken, the word goes straight into the shift register and the holding register stays empty. Received words go out on a valid/ready stream. `rx_valid` stays high until a cycle with `rx_ready` high. The serial line cannot be stalled, so a word that completes while `rx_valid` is high overwrites the unread word and raises overrun.

In master mode, taking a word starts a transfer: `cs_n_out` drops, and SCLK toggles every `cfg_div` system clocks. In slave mode, the block follows `sclk_in` and `cs_n_in`, which pass through two synchronizing flops. Each level of the external clock must therefore last at least three system clocks. Configuration may change only while no transfer is in flight and the receive register is empty.

Top module: `spi_xcvr`

## Requirements
- R1: After reset, `status` is 0x00, `tx_ready` is 1, `rx_valid` is 0, `cs_n_out` is 1 and `sclk_out` is 0.
- R2: In master mode, taking a word drops `cs_n_out` and produces `cfg_len+1` SCLK pulses on `sdo`, bit `cfg_len` first. Each SCLK level lasts `cfg_div` clocks. `cs_n_out` rises exactly `2*cfg_div*(cfg_len+1)` clocks after the cycle in which the word was taken, and `cs_n_out` high implies `sclk_out` low.
- R3: A word taken while the shifter is idle never sets TX-full: status bit 2 and bit 6 stay 0, and `tx_ready` stays 1.
- R4: A word taken while a transfer runs sets TX-full (bit 2 and bit 6), which drops `tx_ready`. In master mode, that word follows the current one with no rise of `cs_n_out` between them.
- R5: A completed word appears on `rx_data[cfg_len:0]`, and the upper bits read 0. RX-full (bit 3 and bit 7) equals `rx_valid`, and a cycle with `rx_ready` clears it.
- R6: A word that completes while `rx_valid` is high replaces the held word and sets overrun (bit 4).
- R7: In slave mode, the word shifts out on `sdo` under `sclk_in` while `cs_n_in` is low, and the word received on `sdi` is delivered as in R5.
- R8: In slave mode, if no word was loaded when a word's first SCLK rise arrives, underrun (bit 0) sets and that word is sent as all zeros.
- R9: In slave mode, raising `cs_n_in` after a word's first rise but before its last fall sets break (bit 5) and delivers no word.
- R10: Bits 0, 4 and 5 stay set until a cycle with `st_clr` high and a 1 in the same position of `st_clr_mask`. Mask positions that are 0 leave their bit unchanged.
- R11: Status bit 1 is 1 while the shift register holds a word to send or in flight: a master transfer, or in slave mode a loaded or partly shifted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_len | input | 4 | Word length minus one |
| cfg_div | input | 8 | Master SCLK half period in clocks (0 acts as 1) |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word can be taken |
| tx_data | input | 16 | Transmit word; bits above cfg_len ignored |
| rx_valid | output | 1 | Received word held |
| rx_ready | input | 1 | Consume the received word |
| rx_data | output | 16 | Received word, zero above cfg_len |
| status | output | 8 | {RX full, TX full, break, overrun, RX full, TX full, running, underrun} |
| st_clr | input | 1 | Clear strobe for sticky bits |
| st_clr_mask | input | 8 | Write-one-to-clear mask |
| sclk_out | output | 1 | Master serial clock |
| cs_n_out | output | 1 | Master chip select, active low |
| sclk_in | input | 1 | Slave serial clock |
| cs_n_in | input | 1 | Slave chip select, active low |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |
| sdo | output | 1 | Serial data out |

## Verification
The bench sweeps random lengths, dividers and data in master mode. It times the select window to the clock. A divider off by one stretches that window, and a wrong bit order corrupts both the looped-back and the captured words. It queues a second word behind a running one and holds the receive side full. A design that drops select between queued words, or that fails to flag the overwrite, is caught there. In slave mode it checks the idle-load bypass and a transfer with nothing loaded, which must send zeros and flag underrun. It also releases select after two bits, which must flag break without delivering a word, and it clears each sticky bit separately so that a clear reaching the wrong bit is exposed.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
  // Status byte positions (host decodes these)
  localparam int ST_URUN  = 0;
  localparam int ST_RUN   = 1;
  localparam int ST_TXF   = 2;
  localparam int ST_RXF   = 3;
  localparam int ST_ORUN  = 4;
  localparam int ST_BRK   = 5;
  localparam int ST_TXFF  = 6;
  localparam int ST_RXFF  = 7;
  localparam int SYNC_STG = 2;
endpackage

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_cnt,
  output logic             rise_o,
  output logic             fall_o,
  output logic             sclk_o
);
  logic [DIV_W-1:0] cnt;
  logic             phase;
  logic             at_end;

  assign at_end = ({1'b0, cnt} + 1'b1) >= {1'b0, half_cnt};
  assign rise_o = run & at_end & ~phase;
  assign fall_o = run & at_end & phase;
  assign sclk_o = phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (at_end) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_end) |=> $stable(phase)); // R2
endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
  parameter int STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic cs_n_in,
  input  logic sdi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_rise,
  output logic cs_low,
  output logic sdi_s
);
  logic [STG:0]   sclk_q;
  logic [STG:0]   cs_q;
  logic [STG-1:0] sdi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      sdi_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[STG-1:0], sclk_in};
      cs_q   <= {cs_q[STG-1:0], cs_n_in};
      sdi_q  <= {sdi_q[STG-2:0], sdi};
    end
  end

  assign sclk_rise = sclk_q[STG-1] & ~sclk_q[STG];
  assign sclk_fall = ~sclk_q[STG-1] & sclk_q[STG];
  assign cs_rise   = cs_q[STG-1] & ~cs_q[STG];
  assign cs_low    = ~cs_q[STG-1];
  assign sdi_s     = sdi_q[STG-1];
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DIV_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_master,
  input  logic [$clog2(DW)-1:0] cfg_len,
  input  logic [DIV_W-1:0]      cfg_div,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [DW-1:0]         tx_data,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic [DW-1:0]         rx_data,
  output logic [7:0]            status,
  input  logic                  st_clr,
  input  logic [7:0]            st_clr_mask,
  output logic                  sclk_out,
  output logic                  cs_n_out,
  input  logic                  sclk_in,
  input  logic                  cs_n_in,
  input  logic                  sdi,
  output logic                  sdo
);
  localparam int LW = $clog2(DW);

  logic [DW-1:0] tx_sh, rx_sh, tx_buf, rx_buf, len_mask;
  logic [LW-1:0] bit_cnt;
  logic tx_full, rx_full, busy, fresh, in_word;
  logic brk, orun, urun;
  logic m_rise, m_fall;
  logic s_rise, s_fall, s_cs_rise, s_cs_low, s_sdi;
  logic smp, shf, word_end, s_first, s_abort, refill, wr_fire, pop, direct, sin;

  spi_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy & cfg_master), .half_cnt(cfg_div),
    .rise_o(m_rise), .fall_o(m_fall), .sclk_o(sclk_out)
  );

  spi_slave_sync #(.STG(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .cs_n_in(cs_n_in), .sdi(sdi),
    .sclk_rise(s_rise), .sclk_fall(s_fall), .cs_rise(s_cs_rise),
    .cs_low(s_cs_low), .sdi_s(s_sdi)
  );

  assign len_mask = ~({DW{1'b1}} << cfg_len << 1);
  assign tx_ready = ~tx_full;
  assign wr_fire  = tx_valid & ~tx_full;
  assign rx_valid = rx_full;
  assign rx_data  = rx_buf;
  assign pop      = rx_full & rx_ready;
  assign cs_n_out = ~(busy & cfg_master);
  assign sdo      = tx_sh[cfg_len];

  assign sin      = cfg_master ? sdi : s_sdi;
  assign smp      = cfg_master ? m_rise : (s_rise & s_cs_low);
  assign shf      = cfg_master ? m_fall : (s_fall & s_cs_low & in_word);
  assign word_end = shf && (bit_cnt == cfg_len);
  assign s_first  = ~cfg_master & s_rise & s_cs_low & ~in_word;
  assign s_abort  = ~cfg_master & s_cs_rise & in_word;
  assign refill   = word_end | s_abort;
  // word goes straight to the shifter when nothing waits ahead of it
  assign direct   = wr_fire & (refill |
                    (cfg_master ? ~busy : (~in_word & ~fresh & ~s_first)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0; rx_sh <= '0; tx_buf <= '0; rx_buf <= '0;
      bit_cnt <= '0; tx_full <= 1'b0; rx_full <= 1'b0;
      busy <= 1'b0; fresh <= 1'b0; in_word <= 1'b0;
      brk <= 1'b0; orun <= 1'b0; urun <= 1'b0;
    end else begin
      if (st_clr) begin
        if (st_clr_mask[ST_BRK])  brk  <= 1'b0;
        if (st_clr_mask[ST_ORUN]) orun <= 1'b0;
        if (st_clr_mask[ST_URUN]) urun <= 1'b0;
      end
      if (pop) rx_full <= 1'b0;
      if (smp) rx_sh <= {rx_sh[DW-2:0], sin};
      if (s_first) begin
        in_word <= 1'b1;
        fresh   <= 1'b0;
        if (!fresh) urun <= 1'b1;
      end
      if (shf && !word_end) begin
        tx_sh   <= tx_sh << 1;
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (word_end) begin
        rx_buf  <= rx_sh & len_mask;
        rx_full <= 1'b1;
        if (rx_full && !pop) orun <= 1'b1;
      end
      if (s_abort) brk <= 1'b1;
      if (refill) begin
        bit_cnt <= '0;
        in_word <= 1'b0;
        if (tx_full || direct) begin
          tx_sh   <= tx_full ? tx_buf : tx_data;
          tx_full <= 1'b0;
          fresh   <= ~cfg_master;
        end else begin
          tx_sh <= '0;
          fresh <= 1'b0;
          busy  <= 1'b0;
        end
      end else if (wr_fire) begin
        if (direct) begin
          tx_sh <= tx_data;
          if (cfg_master) begin
            busy    <= 1'b1;
            bit_cnt <= '0;
          end else begin
            fresh <= 1'b1;
          end
        end else begin
          tx_buf  <= tx_data;
          tx_full <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    status          = '0;
    status[ST_URUN] = urun;
    status[ST_RUN]  = cfg_master ? busy : (fresh | in_word);
    status[ST_TXF]  = tx_full;
    status[ST_RXF]  = rx_full;
    status[ST_ORUN] = orun;
    status[ST_BRK]  = brk;
    status[ST_TXFF] = tx_full;
    status[ST_RXFF] = rx_full;
  end

  AST_IDLE_NO_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_out |-> !sclk_out); // R2
  AST_BYPASS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && wr_fire && !busy) |=> !tx_full); // R3
  AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data & ~len_mask) == '0)); // R5
  AST_ORUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_ORUN] && !(st_clr && st_clr_mask[ST_ORUN])) |=> status[ST_ORUN]); // R10
  AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_BRK] && !(st_clr && st_clr_mask[ST_BRK])) |=> status[ST_BRK]); // R10
  AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_URUN] && !(st_clr && st_clr_mask[ST_URUN])) |=> status[ST_URUN]); // R10
endmodule

// File: tb/test_spi_xcvr.sv
module test_spi_xcvr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_master = 1'b1;
  logic [3:0] cfg_len = 4'd7;
  logic [7:0] cfg_div = 8'd2;
  logic tx_valid = 1'b0, rx_ready = 1'b0, st_clr = 1'b0;
  logic [15:0] tx_data = '0;
  logic [7:0] st_clr_mask = '0;
  logic sclk_in = 1'b0, cs_n_in = 1'b1, sdi = 1'b0;
  logic tx_ready, rx_valid, sclk_out, cs_n_out, sdo;
  logic [15:0] rx_data;
  logic [7:0] status;

  int n_chk = 0, n_fail = 0;
  logic [31:0] bs_sh, bs_mosi;
  int rises = 0, cs_rises = 0;

  always #4 clk = ~clk;

  spi_xcvr i_spi_xcvr (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_len(cfg_len),
    .cfg_div(cfg_div), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .status(status),
    .st_clr(st_clr), .st_clr_mask(st_clr_mask), .sclk_out(sclk_out),
    .cs_n_out(cs_n_out), .sclk_in(sclk_in), .cs_n_in(cs_n_in), .sdi(sdi), .sdo(sdo)
  );

  // bench-side slave for master mode: stream of bits from bs_sh[31]
  always @(posedge sclk_out) begin
    bs_mosi = {bs_mosi[30:0], sdo};
    rises++;
  end
  always @(negedge sclk_out) if (!cs_n_out) begin
    bs_sh = bs_sh << 1;
    if (cfg_master) sdi = bs_sh[31];
  end
  always @(posedge cs_n_out) cs_rises++;

  function automatic logic [15:0] lmask(input int len);
    return 16'((32'h1 << (len + 1)) - 1);
  endfunction
  function automatic logic [31:0] align(input logic [15:0] w, input int len, input int slot);
    return (32'(w & lmask(len))) << (32 - (len + 1) * (slot + 1));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    @(negedge clk) tx_valid = 1'b1; tx_data = w;
    @(negedge clk) tx_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
  endtask

  task automatic clear(input logic [7:0] m);
    @(negedge clk) st_clr = 1'b1; st_clr_mask = m;
    @(negedge clk) st_clr = 1'b0; st_clr_mask = '0;
  endtask

  task automatic wait_cs_high(output int cyc);
    cyc = 0;
    while (cs_n_out !== 1'b1) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic master_one(input int len, input int div, input logic [15:0] w,
                            input logic [15:0] sw);
    int cyc;
    cfg_master = 1'b1; cfg_len = 4'(len); cfg_div = 8'(div);
    @(negedge clk);
    bs_sh = align(sw, len, 0); sdi = bs_sh[31]; bs_mosi = '0; rises = 0;
    tx_valid = 1'b1; tx_data = w;
    chk("R3 ready before write", tx_ready, 1);
    @(negedge clk) tx_valid = 1'b0;
    chk("R3 tx-full stays clear", {status[6], status[2], tx_ready}, 3'b001);
    chk("R11 running", status[1], 1);
    chk("R2 cs low", cs_n_out, 0);
    wait_cs_high(cyc);
    chk("R2 window length", cyc, 2 * div * (len + 1));
    chk("R2 pulse count", rises, len + 1);
    chk("R2 mosi bits", bs_mosi & 32'(lmask(len)), 32'(w & lmask(len)));
    chk("R5 rx word", {rx_valid, status[7], status[3], rx_data}, {3'b111, sw & lmask(len)});
    pop();
    chk("R5 pop clears", {rx_valid, status[3]}, 2'b00);
  endtask

  task automatic slave_word(input int len, input logic [15:0] sw, output logic [15:0] got);
    got = '0;
    cs_n_in = 1'b0;
    for (int i = len; i >= 0; i--) begin
      sdi = sw[i];
      repeat (6) @(negedge clk);
      got = {got[14:0], sdo};
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
      sclk_in = 1'b0;
    end
    repeat (6) @(negedge clk);
    cs_n_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    int len;
    logic [15:0] w1, w2, s1, s2, got;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset handshake", {tx_ready, rx_valid}, 2'b10);
    chk("R1 reset lines", {cs_n_out, sclk_out}, 2'b10);
    cs_rises = 0;

    // directed extremes, then random master transfers
    master_one(15, 1, 16'hA5C3, 16'h3C5A);
    master_one(0, 3, 16'h0001, 16'hFFFF);
    for (int k = 0; k < 16; k++)
      master_one(1 + int'($urandom_range(14)), 1 + int'($urandom_range(3)),
                 16'($urandom), 16'($urandom));

    // R4 + R6: queued second word, receive side left full
    len = 7; cfg_len = 4'(len); cfg_div = 8'd2;
    w1 = 16'h5A; w2 = 16'hC3; s1 = 16'h81; s2 = 16'h7E;
    @(negedge clk);
    bs_sh = align(s1, len, 0) | align(s2, len, 1); sdi = bs_sh[31]; bs_mosi = '0;
    cs_rises = 0;
    put(w1);
    put(w2);
    chk("R4 tx-full set", {status[6], status[2], tx_ready}, 3'b110);
    wait_cs_high(cyc);
    chk("R4 no cs gap", cs_rises, 1);
    chk("R4 both words out", bs_mosi[15:0], {w1[7:0], w2[7:0]});
    chk("R6 overrun set", status[4], 1);
    chk("R6 newest word kept", rx_data, s2);
    clear(8'h21);
    chk("R10 unmasked bit kept", status[4], 1);
    clear(8'h10);
    chk("R10 overrun cleared", {status[4], rx_valid}, 2'b01);
    pop();

    // slave mode
    cfg_master = 1'b0; cfg_len = 4'd9;
    put(16'h2B7);
    chk("R3 slave bypass", {status[2], status[1]}, 2'b01);
    slave_word(9, 16'h1C4, got);
    chk("R7 slave sdo", got, 16'h2B7);
    chk("R7 slave rx", {rx_valid, rx_data}, {1'b1, 16'h1C4});
    chk("R8 no underrun", status[0], 0);
    pop();
    cfg_len = 4'd5;
    slave_word(5, 16'h2A, got);
    chk("R8 underrun zeros", got, 16'h0);
    chk("R8 underrun flag", status[0], 1);
    pop();
    clear(8'h01);
    chk("R10 underrun cleared", status[0], 0);

    // R9: select released after two bits
    put(16'h3F);
    cs_n_in = 1'b0;
    for (int i = 0; i < 2; i++) begin
      repeat (6) @(negedge clk); sclk_in = 1'b1;
      repeat (6) @(negedge clk); sclk_in = 1'b0;
    end
    repeat (6) @(negedge clk); cs_n_in = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 break flag", {status[5], rx_valid}, 2'b10);
    clear(8'h20);
    chk("R9 break cleared", status[5], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule